// File: doc/BRIEF.md
# Scanline Counting Interrupt Generator

This block counts rendered picture lines and asks the CPU for an interrupt once a programmed number of lines has gone by. Software writes a reload value, can force the counter to zero, and can arm or disarm the interrupt. To do this it writes to four control addresses in the top quarter of the CPU address space. The block watches the picture dot and line counters that the video timing logic supplies. On each counted line it moves the counter one step at a fixed dot.

When the counter is zero, a step loads the reload value. In every other case a step decrements the counter. A decrement that reaches zero while the block is armed raises the interrupt request. The request stays high until software disarms the block. Video timing generation and interrupt handling inside the CPU are left to other blocks.

Top module: `scanline_irq_counter`

## Requirements
- R1: After a synchronous reset, the reload value, the counter, the arm flag and `irq` are all zero.
- R2: A step happens only on the clock where `dot` first equals 260. If `dot` stays at 260 on later clocks, no further step follows until `dot` has left 260.
- R3: No step happens while `line` is in the range 240 to 260 inclusive. Lines 0 to 239 and line 261 do step.
- R4: No step happens while `bg_on` and `spr_on` are both low. Either one high is enough.
- R5: A step with the counter at zero loads the reload value. A step with a nonzero counter decrements it. With a reload value of zero, the counter never leaves zero.
- R6: A decrement that reaches zero raises `irq` on the following clock, but only if the block was armed before that write-free clock edge. A decrement while disarmed raises nothing.
- R7: A write with `wr_addr[15:13]` = 3'b110 and `wr_addr[0]` = 0 stores `wr_data` as the reload value. The same range with `wr_addr[0]` = 1 forces the counter to zero.
- R8: A write with `wr_addr[15:13]` = 3'b111 and `wr_addr[0]` = 0 disarms the block and drops `irq` on the next clock. The same range with `wr_addr[0]` = 1 arms the block.
- R9: Once high, `irq` stays high through any number of steps and other writes until a disarming write.
- R10: Writes with `wr_addr[15:14]` other than 2'b11 change no state.
- R11: A counter-clear write on the same clock as a step leaves the counter at zero; the step is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one clock per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| dot | input | 9 | Current dot within the line |
| line | input | 9 | Current line number |
| bg_on | input | 1 | Background rendering enabled |
| spr_on | input | 1 | Sprite rendering enabled |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The hardest cases to reach from the ports are collisions on one clock edge. These are a counter-clear write landing on the very clock of a step, and a step whose dot value is held for several clocks. Ordinary traffic almost never lines these up. The stimulus places them on purpose in directed sequences, where the reload value is chosen so that a lost or doubled step moves the interrupt by a full line. A random phase then keeps `dot` mostly at 259 to 261, so that steps, holds and writes to all four control addresses collide often. Every clock is compared with a bench model built from the requirements.

// File: rtl/scl_pkg.sv
package scl_pkg;
  // Decoded effect of one CPU write on the counter block
  typedef struct packed {
    logic set_reload;
    logic clr_count;
    logic disarm;
    logic arm;
  } scl_cmd_t;
endpackage

// File: rtl/scl_wr_decode.sv
module scl_wr_decode
  import scl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output scl_cmd_t          cmd
);
  localparam logic [2:0] RANGE_CNT = 3'b110;
  localparam logic [2:0] RANGE_ARM = 3'b111;

  logic [2:0] top_bits;
  logic       odd;

  always_comb begin
    top_bits       = wr_addr[ADDR_W-1 -: 3];
    odd            = wr_addr[0];
    cmd.set_reload = wr_en && (top_bits == RANGE_CNT) && !odd;
    cmd.clr_count  = wr_en && (top_bits == RANGE_CNT) &&  odd;
    cmd.disarm     = wr_en && (top_bits == RANGE_ARM) && !odd;
    cmd.arm        = wr_en && (top_bits == RANGE_ARM) &&  odd;
  end
endmodule

// File: rtl/scl_step_detect.sv
module scl_step_detect #(
  parameter int DOT_W     = 9,
  parameter int LINE_W    = 9,
  parameter int STEP_DOT  = 260,
  parameter int BLANK_LO  = 240,
  parameter int BLANK_HI  = 260
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  input  logic              bg_on,
  input  logic              spr_on,
  output logic              step
);
  localparam logic [DOT_W-1:0]  STEP_V = DOT_W'(STEP_DOT);
  localparam logic [LINE_W-1:0] LO_V   = LINE_W'(BLANK_LO);
  localparam logic [LINE_W-1:0] HI_V   = LINE_W'(BLANK_HI);

  logic at_dot;
  logic at_dot_q;
  logic in_blank;

  always_ff @(posedge clk) begin
    if (rst) at_dot_q <= 1'b0;
    else     at_dot_q <= at_dot;
  end

  always_comb begin
    at_dot   = (dot == STEP_V);
    in_blank = (line >= LO_V) && (line <= HI_V);
    step     = at_dot && !at_dot_q && !in_blank && (bg_on || spr_on);
  end
endmodule

// File: rtl/scl_count_core.sv
module scl_count_core
  import scl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  scl_cmd_t         cmd,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             step,
  output logic             armed,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;
  logic             hit_zero;

  // Decrement that lands on zero, not overridden by a clear write
  assign hit_zero = step && !cmd.clr_count && (count_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= ZERO;
      count_q  <= ZERO;
      armed    <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (cmd.set_reload) reload_q <= wr_data;

      if (cmd.clr_count)          count_q <= ZERO;
      else if (step) begin
        if (count_q == ZERO)      count_q <= reload_q;
        else                      count_q <= count_q - ONE;
      end

      if (cmd.disarm)             armed <= 1'b0;
      else if (cmd.arm)           armed <= 1'b1;

      if (cmd.disarm)             irq <= 1'b0;
      else if (hit_zero && armed) irq <= 1'b1;
    end
  end
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import scl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int DOT_W    = 9,
  parameter int LINE_W   = 9,
  parameter int STEP_DOT = 260,
  parameter int BLANK_LO = 240,
  parameter int BLANK_HI = 260
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  input  logic              bg_on,
  input  logic              spr_on,
  output logic              irq
);
  scl_cmd_t cmd;
  logic     step;
  logic     irq_armed;

  scl_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cmd     (cmd)
  );

  scl_step_detect #(
    .DOT_W(DOT_W), .LINE_W(LINE_W), .STEP_DOT(STEP_DOT),
    .BLANK_LO(BLANK_LO), .BLANK_HI(BLANK_HI)
  ) u_step (
    .clk    (clk),
    .rst    (rst),
    .dot    (dot),
    .line   (line),
    .bg_on  (bg_on),
    .spr_on (spr_on),
    .step   (step)
  );

  scl_count_core #(.CNT_W(DATA_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .wr_data (wr_data),
    .step    (step),
    .armed   (irq_armed),
    .irq     (irq)
  );
endmodule

// File: rtl/scanline_irq_counter_chk.sv
module scanline_irq_counter_chk #(
  parameter int ADDR_W   = 16,
  parameter int DOT_W    = 9,
  parameter int LINE_W   = 9,
  parameter int STEP_DOT = 260,
  parameter int BLANK_LO = 240,
  parameter int BLANK_HI = 260
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DOT_W-1:0]  dot,
  input logic [LINE_W-1:0] line,
  input logic              bg_on,
  input logic              spr_on,
  input logic              irq_armed,
  input logic              irq
);
  logic disarm_wr;
  assign disarm_wr = wr_en && (wr_addr[ADDR_W-1 -: 3] == 3'b111) && !wr_addr[0];

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !irq);

  p_only_at_dot_r2: assert property (@(posedge clk) disable iff (rst)
    (!irq && dot != DOT_W'(STEP_DOT)) |=> !irq);

  p_quiet_in_blank_r3: assert property (@(posedge clk) disable iff (rst)
    (!irq && line >= LINE_W'(BLANK_LO) && line <= LINE_W'(BLANK_HI)) |=> !irq);

  p_quiet_no_render_r4: assert property (@(posedge clk) disable iff (rst)
    (!irq && !bg_on && !spr_on) |=> !irq);

  p_no_irq_disarmed_r6: assert property (@(posedge clk) disable iff (rst)
    (!irq && !irq_armed) |=> !irq);

  p_disarm_drops_r8: assert property (@(posedge clk) disable iff (rst)
    disarm_wr |=> (!irq && !irq_armed));

  p_irq_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (irq && !disarm_wr) |=> irq);
endmodule

bind scanline_irq_counter scanline_irq_counter_chk #(
  .ADDR_W(ADDR_W), .DOT_W(DOT_W), .LINE_W(LINE_W), .STEP_DOT(STEP_DOT),
  .BLANK_LO(BLANK_LO), .BLANK_HI(BLANK_HI)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .dot(dot),
  .line(line), .bg_on(bg_on), .spr_on(spr_on), .irq_armed(irq_armed), .irq(irq)
);

// File: tb/scanline_irq_counter_tb.sv
`timescale 1ns/1ps
module scanline_irq_counter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [8:0]  dot = '0;
  logic [8:0]  line = '0;
  logic        bg_on = 1'b1;
  logic        spr_on = 1'b1;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model state
  logic [7:0] m_reload = '0, m_count = '0;
  logic       m_armed = 0, m_irq = 0, m_hit = 0;

  always #4 clk = ~clk;

  scanline_irq_counter u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dot(dot), .line(line), .bg_on(bg_on), .spr_on(spr_on), .irq(irq)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: irq actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_step(input logic [8:0] d, input logic [8:0] l,
                                 input logic b, input logic s, input logic hit);
    return (d == 9'd260) && !hit && !(l >= 9'd240 && l <= 9'd260) && (b || s);
  endfunction

  // One clock: drive at negedge, update model, compare after the edge
  task automatic cyc(input logic we, input logic [15:0] a, input logic [7:0] d,
                     input logic [8:0] dt, input logic [8:0] ln,
                     input logic b, input logic s, input string tag);
    bit st, c_rl, c_clr, c_dis, c_arm;
    wr_en = we; wr_addr = a; wr_data = d; dot = dt; line = ln;
    bg_on = b; spr_on = s;
    st    = is_step(dt, ln, b, s, m_hit);
    c_rl  = we && a[15:13] == 3'b110 && !a[0];
    c_clr = we && a[15:13] == 3'b110 &&  a[0];
    c_dis = we && a[15:13] == 3'b111 && !a[0];
    c_arm = we && a[15:13] == 3'b111 &&  a[0];
    if (c_dis) m_irq = 0;
    else if (st && !c_clr && m_count == 8'd1 && m_armed) m_irq = 1;
    if (c_clr) m_count = 0;
    else if (st) m_count = (m_count == 0) ? m_reload : m_count - 8'd1;
    if (c_rl) m_reload = d;
    if (c_dis) m_armed = 0; else if (c_arm) m_armed = 1;
    m_hit = (dt == 9'd260);
    @(posedge clk); #1;
    chk(irq, m_irq, tag);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 9'd0, 9'd0, 1'b1, 1'b1, "R7");
  endtask

  // one line: dot passes through 260 once
  task automatic do_line(input logic [8:0] ln, input logic b, input logic s, input string tag);
    cyc(0, 16'h0, 8'h0, 9'd259, ln, b, s, tag);
    cyc(0, 16'h0, 8'h0, 9'd260, ln, b, s, tag);
    cyc(0, 16'h0, 8'h0, 9'd261, ln, b, s, tag);
  endtask

  task automatic setup(input logic [7:0] rl, input bit arm);
    wr(16'hE000, 8'h0);
    if (arm) wr(16'hE001, 8'h0);
    wr(16'hC001, 8'h0);
    wr(16'hC000, rl);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    rst = 0;
    #1 chk(irq, 1'b0, "R1");

    // R1: reset left counter and reload at zero, so steps alone give no irq
    wr(16'hE001, 8'h0);
    do_line(9'd1, 1, 1, "R1"); do_line(9'd2, 1, 1, "R1");
    chk(irq, 1'b0, "R1");

    // R5/R6: reload 2 -> load, 1, 0
    setup(8'd2, 1);
    do_line(9'd10, 1, 1, "R5"); do_line(9'd11, 1, 1, "R5");
    chk(irq, 1'b0, "R5");
    do_line(9'd12, 1, 1, "R6");
    chk(irq, 1'b1, "R6");
    // R9: stays high through steps and other writes
    do_line(9'd13, 1, 1, "R9"); wr(16'hC000, 8'd7); wr(16'hE001, 8'h0);
    do_line(9'd14, 1, 1, "R9"); do_line(9'd15, 1, 1, "R9");
    chk(irq, 1'b1, "R9");
    // R8: disarm drops irq
    wr(16'hE000, 8'h0);
    chk(irq, 1'b0, "R8");

    // R2: dot held at 260 counts once
    setup(8'd1, 1);
    cyc(0, 0, 0, 9'd260, 9'd20, 1, 1, "R2");
    cyc(0, 0, 0, 9'd260, 9'd20, 1, 1, "R2");
    cyc(0, 0, 0, 9'd260, 9'd20, 1, 1, "R2");
    cyc(0, 0, 0, 9'd261, 9'd20, 1, 1, "R2");
    chk(irq, 1'b0, "R2");
    do_line(9'd21, 1, 1, "R2");
    chk(irq, 1'b1, "R2");

    // R3: blank lines do not count, line 261 does
    setup(8'd1, 1);
    do_line(9'd5, 1, 1, "R3");
    do_line(9'd240, 1, 1, "R3"); do_line(9'd250, 1, 1, "R3"); do_line(9'd260, 1, 1, "R3");
    chk(irq, 1'b0, "R3");
    do_line(9'd261, 1, 1, "R3");
    chk(irq, 1'b1, "R3");

    // R4: rendering off does not count, sprites alone do
    setup(8'd1, 1);
    do_line(9'd5, 1, 0, "R4");
    do_line(9'd6, 0, 0, "R4");
    chk(irq, 1'b0, "R4");
    do_line(9'd7, 0, 1, "R4");
    chk(irq, 1'b1, "R4");

    // R6: decrement to zero while disarmed
    setup(8'd1, 0);
    do_line(9'd1, 1, 1, "R6"); do_line(9'd2, 1, 1, "R6");
    chk(irq, 1'b0, "R6");
    wr(16'hE001, 8'h0);
    do_line(9'd3, 1, 1, "R6"); do_line(9'd4, 1, 1, "R6");
    chk(irq, 1'b1, "R6");

    // R5: reload zero never leaves zero
    setup(8'd0, 1);
    for (int i = 0; i < 5; i++) do_line(9'(30 + i), 1, 1, "R5");
    chk(irq, 1'b0, "R5");

    // R10: writes outside the control space are ignored
    setup(8'd1, 1);
    do_line(9'd40, 1, 1, "R10");
    cyc(1, 16'hA001, 8'h0, 9'd0, 9'd41, 1, 1, "R10");
    cyc(1, 16'hA000, 8'h5, 9'd0, 9'd41, 1, 1, "R10");
    cyc(1, 16'h8000, 8'h0, 9'd0, 9'd41, 1, 1, "R10");
    cyc(1, 16'h6001, 8'h0, 9'd0, 9'd41, 1, 1, "R10");
    do_line(9'd42, 1, 1, "R10");
    chk(irq, 1'b1, "R10");

    // R11: clear write on the step clock wins
    setup(8'd2, 1);
    do_line(9'd50, 1, 1, "R11");
    cyc(0, 0, 0, 9'd259, 9'd51, 1, 1, "R11");
    cyc(1, 16'hC001, 0, 9'd260, 9'd51, 1, 1, "R11");
    cyc(0, 0, 0, 9'd261, 9'd51, 1, 1, "R11");
    do_line(9'd52, 1, 1, "R11");
    do_line(9'd53, 1, 1, "R11");
    chk(irq, 1'b0, "R11");
    do_line(9'd54, 1, 1, "R11");
    chk(irq, 1'b1, "R11");

    // random phase against the model
    for (int i = 0; i < 6000; i++) begin
      logic [15:0] a;
      logic [8:0]  dt, ln;
      logic        we;
      case ($urandom % 6)
        0: a = 16'hC000; 1: a = 16'hC001; 2: a = 16'hE000;
        3: a = 16'hE001; default: a = 16'($urandom);
      endcase
      we = ($urandom % 5) == 0;
      if (($urandom % 6) != 0) dt = 9'(259 + ($urandom % 3));
      else dt = 9'($urandom % 341);
      ln = 9'($urandom % 262);
      cyc(we, a, 8'($urandom % 4), dt, ln, 1'($urandom % 4 != 0),
          1'($urandom % 2), "R6");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule